// File: doc/BRIEF.md
# Subroutine call sequencer

This block produces the memory traffic of an absolute subroutine-call instruction on an 8-bit processor whose stack grows downward inside a fixed stack page. The caller supplies the address of the opcode byte and the current stack pointer and pulses `start`. Over the next six cycles the block fetches the two-byte call target and stores the return link on the stack. It then reports the new program counter and the decremented stack pointer.

The bus steps come in a fixed order. The low target byte is read first. The high and then the low byte of the return link are written next. The high target byte is read last. Because of this order, a call whose operand lies inside the stack page picks up the byte that was just pushed in place of the byte originally stored there. Memory reads have one cycle of latency: data requested in one cycle arrives on `mem_rdata` in the next cycle. Exactly one bus strobe is raised in each access cycle, and none in the internal cycles.

Top module: `subr_call_seq`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low, and it captures `op_addr` and `sp_in`. A `start` pulse while `busy` is high has no effect on the bus traffic or on the results.
- R2: Count the cycle after the accepting clock edge as cycle 1. Cycle 1 reads `op_addr+1`, cycle 3 writes, cycle 4 writes and cycle 5 reads `op_addr+2`. Read data is taken from `mem_rdata` in the cycle after the read strobe.
- R3: Cycles 2 and 6 raise no strobe. `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.
- R4: The cycle-3 write stores bits 15:8 of `op_addr+2` at address {STACK_PAGE, SP}. The cycle-4 write stores bits 7:0 of `op_addr+2` at {STACK_PAGE, SP-1}. STACK_PAGE defaults to 8'h01.
- R5: Each push decrements the stack pointer modulo 256, so `sp_out` equals `sp_in-2` modulo 256 (for example, 8'h00 gives 8'hFE).
- R6: `pc_out` is {high byte, low byte}. The high byte is the one read in cycle 5, after both pushes, so a high operand byte that sits where the first push landed returns the pushed byte.
- R7: `busy` is high in cycles 1 to 6. `done` is high for exactly one cycle, cycle 7. `pc_out` and `sp_out` update in that cycle and hold until the next completion.
- R8: While `rst` is high and just after it falls, `busy`, `done`, `mem_rd`, `mem_wr`, `pc_out` and `sp_out` are all zero.
- R9: Operand and return-link addresses wrap modulo 2^16 (an opcode at 16'hFFFE reads 16'hFFFF and then 16'h0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call sequence |
| op_addr | input | 16 | Address of the opcode byte |
| sp_in | input | 8 | Stack pointer at the start of the call |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Call target |
| sp_out | output | 8 | Stack pointer after the pushes |

## Verification
The assertions check the bus on every cycle. They confirm that the two strobes are never high together and that no strobe appears while idle. They confirm that every write lands in the stack page, that two writes are always followed by a read, and that the second write address is one below the first. They also confirm that `done` is a single-cycle pulse that follows `busy`. Only the bench scenarios can show the data values and the exact cycle numbers of each access. The same holds for the stack-page overlap, where the target's high byte must come back as the pushed link byte, and for address wrap at both the stack and the 64K boundary. Rejection of a `start` raised mid-sequence is also covered only by the scenarios.

// File: rtl/subr_call_pkg.sv
`timescale 1ns/1ps
package subr_call_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RD_LO    = 3'd1,
    PH_LATCH_LO = 3'd2,
    PH_PUSH_HI  = 3'd3,
    PH_PUSH_LO  = 3'd4,
    PH_RD_HI    = 3'd5,
    PH_FINISH   = 3'd6
  } phase_t;
endpackage

// File: rtl/subr_call_fsm.sv
`timescale 1ns/1ps
module subr_call_fsm
  import subr_call_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   accept
);
  assign accept = start && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:     if (accept) phase <= PH_RD_LO;
        PH_RD_LO:    phase <= PH_LATCH_LO;
        PH_LATCH_LO: phase <= PH_PUSH_HI;
        PH_PUSH_HI:  phase <= PH_PUSH_LO;
        PH_PUSH_LO:  phase <= PH_RD_HI;
        PH_RD_HI:    phase <= PH_FINISH;
        default:     phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subr_call_regs.sv
`timescale 1ns/1ps
module subr_call_regs
  import subr_call_pkg::*;
#(
  parameter int  DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  phase_t        phase,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] op_q,
  output logic [DW-1:0] sp_q,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic          done
);
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      sp_q   <= '0;
      lo_q   <= '0;
      pc_out <= '0;
      sp_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q <= op_addr;
        sp_q <= sp_in;
      end
      case (phase)
        PH_LATCH_LO: lo_q <= mem_rdata;
        PH_PUSH_HI,
        PH_PUSH_LO:  sp_q <= sp_q - 1'b1;
        PH_FINISH: begin
          pc_out <= {mem_rdata, lo_q};
          sp_out <= sp_q;
          done   <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/subr_call_bus.sv
`timescale 1ns/1ps
module subr_call_bus
  import subr_call_pkg::*;
#(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  localparam int           AW         = 2 * DW
) (
  input  phase_t        phase,
  input  logic [AW-1:0] op_q,
  input  logic [DW-1:0] sp_q,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic [AW-1:0] link;
  logic [AW-1:0] lo_ptr;

  assign lo_ptr = op_q + AW'(1);
  assign link   = op_q + AW'(2);

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (phase)
      PH_RD_LO: begin
        mem_rd   = 1'b1;
        mem_addr = lo_ptr;
      end
      PH_PUSH_HI: begin
        mem_wr    = 1'b1;
        mem_addr  = {STACK_PAGE, sp_q};
        mem_wdata = link[AW-1:DW];
      end
      PH_PUSH_LO: begin
        mem_wr    = 1'b1;
        mem_addr  = {STACK_PAGE, sp_q};
        mem_wdata = link[DW-1:0];
      end
      PH_RD_HI: begin
        mem_rd   = 1'b1;
        mem_addr = link;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/subr_call_seq.sv
`timescale 1ns/1ps
module subr_call_seq
  import subr_call_pkg::*;
#(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  localparam int           AW         = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] sp_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out
);
  phase_t        phase;
  logic          accept;
  logic [AW-1:0] op_q;
  logic [DW-1:0] sp_q;

  assign busy = (phase != PH_IDLE);

  subr_call_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .phase  (phase),
    .accept (accept)
  );

  subr_call_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .phase     (phase),
    .op_addr   (op_addr),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .op_q      (op_q),
    .sp_q      (sp_q),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .done      (done)
  );

  subr_call_bus #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_bus (
    .phase     (phase),
    .op_q      (op_q),
    .sp_q      (sp_q),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: rtl/subr_call_seq_chk.sv
`timescale 1ns/1ps
module subr_call_seq_chk #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  localparam int           AW         = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr
);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  a_r4_stack_page: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr[AW-1:DW] == STACK_PAGE));

  a_r2_pushes_paired: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |=> mem_wr);

  a_r2_read_after_pushes: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |=> mem_rd);

  a_r5_sp_step: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |->
      (mem_addr[DW-1:0] == DW'($past(mem_addr[DW-1:0]) - 1'b1)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind subr_call_seq subr_call_seq_chk #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr)
);

// File: tb/test_subr_call_seq.sv
`timescale 1ns/1ps
module test_subr_call_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] op_addr = '0;
  logic [7:0]  sp_in = '0;
  logic        mem_rd, mem_wr, busy, done;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, sp_out;
  logic [7:0]  mem_rdata = '0;

  int nchecks = 0;
  int nerrs   = 0;
  int cyc     = 0;

  typedef struct {
    bit          is_wr;
    int          at;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } bus_item_t;
  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp;
  } res_item_t;

  bus_item_t bus_q[$];
  res_item_t res_q[$];
  logic [7:0] mem  [int];
  logic [7:0] refm [int];
  logic [15:0] last_pc;
  logic [7:0]  last_sp;

  always #2 clk = ~clk;

  subr_call_seq i_subr_call_seq (
    .clk(clk), .rst(rst), .start(start), .op_addr(op_addr), .sp_in(sp_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
  endfunction

  task automatic poke(input logic [15:0] a, input logic [7:0] v);
    mem[int'(a)]  = v;
    refm[int'(a)] = v;
  endtask

  // driver: waits for idle, predicts the traffic, pulses start
  task automatic issue(input logic [15:0] op, input logic [7:0] sp);
    logic [15:0] lnk, a_lo, a_hi;
    logic [7:0]  lo, hi, s1, s2;
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    a_lo = op + 16'd1;
    lnk  = op + 16'd2;
    a_hi = lnk;
    lo   = ref_rd(a_lo);
    refm[int'({8'h01, sp})] = lnk[15:8];
    s1 = sp - 8'd1;
    refm[int'({8'h01, s1})] = lnk[7:0];
    s2 = s1 - 8'd1;
    hi = ref_rd(a_hi);
    bus_q.push_back('{1'b0, 1, a_lo, 8'h00, "R2"});
    bus_q.push_back('{1'b1, 3, {8'h01, sp}, lnk[15:8], "R4"});
    bus_q.push_back('{1'b1, 4, {8'h01, s1}, lnk[7:0], "R4"});
    bus_q.push_back('{1'b0, 5, a_hi, 8'h00, "R9"});
    res_q.push_back('{{hi, lo}, s2});
    last_pc = {hi, lo};
    last_sp = s2;
    start = 1'b1; op_addr = op; sp_in = sp;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (mem_rd || mem_wr) begin
        if (bus_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected strobe at addr", {16'h0, mem_addr}, 32'h0);
        end else begin
          bus_item_t e;
          e = bus_q.pop_front();
          chk(mem_wr == e.is_wr, "R2", "access kind (1=write)", {31'h0, mem_wr}, {31'h0, e.is_wr});
          chk(cyc == e.at, "R2", "access cycle", cyc, e.at);
          chk(mem_addr == e.addr, e.req, "access address", {16'h0, mem_addr}, {16'h0, e.addr});
          if (e.is_wr)
            chk(mem_wdata == e.data, "R4", "pushed byte", {24'h0, mem_wdata}, {24'h0, e.data});
        end
      end
      if (done) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected done", 32'h1, 32'h0);
        end else begin
          res_item_t r;
          r = res_q.pop_front();
          chk(cyc == 7, "R7", "done cycle", cyc, 7);
          chk(pc_out == r.pc, "R6", "pc_out", {16'h0, pc_out}, {16'h0, r.pc});
          chk(sp_out == r.sp, "R5", "sp_out", {24'h0, sp_out}, {24'h0, r.sp});
        end
      end
      if (start && !busy) cyc = 0;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || done || res_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    nerrs++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs during reset
    chk(!busy && !done && !mem_rd && !mem_wr, "R8", "control outputs in reset",
        {28'h0, busy, done, mem_rd, mem_wr}, 32'h0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(pc_out == 16'h0 && sp_out == 8'h0 && !busy, "R8", "results after reset",
        {8'h0, pc_out, sp_out}, 32'h0);

    // plain call
    poke(16'h1001, 8'h34); poke(16'h1002, 8'h12);
    issue(16'h1000, 8'hFF);
    wait_idle();

    // R6: high operand byte sits where the first push lands
    poke(16'h01FE, 8'h34); poke(16'h01FF, 8'hAB);
    issue(16'h01FD, 8'hFF);
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(pc_out[15:8] == 8'h01, "R6", "overlap high byte is pushed link byte",
        {24'h0, pc_out[15:8]}, 32'h01);
    wait_idle();

    // R5: stack pointer wraps from 00
    poke(16'h2201, 8'hCD); poke(16'h2202, 8'hEF);
    issue(16'h2200, 8'h00);
    wait_idle();

    // R9: operand addresses wrap at 64K
    poke(16'hFFFF, 8'h78); poke(16'h0000, 8'h56);
    issue(16'hFFFE, 8'h80);
    wait_idle();

    // low operand byte overlaps the second push, read before it
    poke(16'h0100, 8'h9A); poke(16'h0101, 8'h44);
    issue(16'h00FF, 8'h01);
    wait_idle();

    // back-to-back calls accepted in the done cycle
    poke(16'h3001, 8'h11); poke(16'h3002, 8'h22);
    poke(16'h4001, 8'h33); poke(16'h4002, 8'h44);
    issue(16'h3000, 8'hF0);
    issue(16'h4000, 8'hE0);
    wait_idle();

    // R1: start raised while busy must be ignored
    poke(16'h5001, 8'h66); poke(16'h5002, 8'h77);
    issue(16'h5000, 8'hC0);
    @(posedge clk); #1;
    start = 1'b1; op_addr = 16'h6000; sp_in = 8'h10;
    @(posedge clk); #1;
    start = 1'b0;
    wait_idle();
    chk(pc_out == 16'h7766, "R1", "pc_out after mid-sequence start", {16'h0, pc_out}, 32'h7766);

    // R7: results hold while idle
    repeat (5) @(negedge clk);
    chk(pc_out == last_pc && sp_out == last_sp, "R7", "results held while idle",
        {8'h0, pc_out, sp_out}, {8'h0, last_pc, last_sp});
    chk(bus_q.size() == 0, "R2", "all predicted accesses seen", bus_q.size(), 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule